// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Output-Bus Control

This block is the serial test port of a memory device. A four-wire interface (test clock, mode select, serial data in and serial data out) walks a sixteen-state controller. That controller moves bits through a 3-bit instruction register and through one of three data paths. The paths are a 32-bit identification code, a single bypass bit, and a 109-cell boundary register that can snapshot the device pins and hold a parallel preload pattern.

The current instruction, together with the preloaded control cell at position 108, decides who owns the device's data-output bus. It can stay under functional control. The boundary logic can drive the preload pattern onto it. It can also be forced to high impedance. The memory core and pad buffers sit outside. They consume `pin_drv_o`, `bnd_drive_o` and `q_hiz_o`, and they feed the pin snapshot into `pin_smp_i`.

Top module: `bscan_tap_ctl`

## Requirements
- R1: After the reset input is asserted, or on entry to Test-Logic-Reset, IDCODE (001) is the current instruction, `tdo_en_o` is 0, and both `bnd_drive_o` and `q_hiz_o` are 0.
- R2: With the mode-select input high on five consecutive rising test-clock edges, the controller reaches Test-Logic-Reset from any state, including Pause-DR.
- R3: Capture-IR loads the pattern 001 into the instruction shift stage, which shifts out least-significant bit first. A shifted-in code becomes current only at Update-IR, so the output-control signals keep their values until then.
- R4: With IDCODE current, Capture-DR loads the 32-bit identification code (bit 0 = 1), which shifts out LSB first.
- R5: BYPASS (111) selects a 1-bit register that captures 0, so TDO repeats TDI one shift later.
- R6: The unused codes 011, 101 and 110 behave exactly as BYPASS.
- R7: SAMPLE/PRELOAD (100) selects the boundary register. Capture-DR loads cell i from `pin_smp_i[i]`, and cell 0 shifts out first while new data shifts in at cell 108. The output bus stays under functional control (`bnd_drive_o` = 0, `q_hiz_o` = 0).
- R8: Update-DR copies the boundary shift stage to `pin_drv_o` only while a boundary instruction (000, 010 or 100) is current. Under any other instruction the preload is left unchanged.
- R9: EXTEST (000) selects and captures the boundary register as in R7, sets `bnd_drive_o` to 1, and sets `q_hiz_o` to the inverse of preload cell 108.
- R10: SAMPLE Z (010) selects and captures the boundary register, forces `q_hiz_o` to 1 with `bnd_drive_o` at 0, and keeps this until another instruction becomes current at Update-IR.
- R11: Preload cell 108 is set to 1 by the reset input and on every entry to Test-Logic-Reset. The other preload cells reset to 0 and keep their value on entry to Test-Logic-Reset.
- R12: TDO and its enable change only on the falling test-clock edge. The enable is 1 only in Shift-IR and Shift-DR, and TDO is 0 whenever the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_n_i | input | 1 | Asynchronous active-low power-up reset |
| tms_i | input | 1 | Mode select, sampled on the rising test-clock edge |
| tdi_i | input | 1 | Serial data in, sampled on the rising test-clock edge |
| tdo_o | output | 1 | Serial data out, updated on the falling edge |
| tdo_en_o | output | 1 | TDO output-buffer enable |
| pin_smp_i | input | 109 | Device pin values for the boundary snapshot |
| pin_drv_o | output | 109 | Preload pattern for boundary-driven pins |
| bnd_drive_o | output | 1 | Pads take their values from the preload pattern |
| q_hiz_o | output | 1 | Data-output bus forced to high impedance |

## Verification
Instruction-driven outputs (`bnd_drive_o`, `q_hiz_o`) change on the rising edge taken in Update-IR. Preload values change on the rising edge taken in Update-DR. The bench steps the controller one edge per task call and samples 1 ns after that edge. The same comparison is also made at Exit1-IR, before the update, to show nothing moved early.

The first bit of a shift appears on TDO at the falling edge after Shift-IR or Shift-DR is entered, and each later bit appears one falling edge further on. The scoreboard queues expected bits before the shift begins. The monitor pops one bit 2 ns after every falling edge with the enable high, then re-reads TDO just after the next rising edge to confirm it held.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   typedef enum logic [3:0] {
      TAP_RESET, TAP_IDLE,
      TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
      TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
   } tap_st_e;

   typedef enum logic [1:0] {DR_BYP, DR_IDC, DR_BND} dr_sel_e;

   // opcodes on the 3 low instruction bits
   localparam logic [2:0] OP_EXTEST = 3'b000;
   localparam logic [2:0] OP_IDCODE = 3'b001;
   localparam logic [2:0] OP_SAMPZ  = 3'b010;
   localparam logic [2:0] OP_SAMPLE = 3'b100;
   localparam logic [2:0] OP_BYPASS = 3'b111;

   function automatic tap_st_e tap_next(input tap_st_e s, input logic tms);
      tap_st_e n;
      case (s)
         TAP_RESET:  n = tms ? TAP_RESET  : TAP_IDLE;
         TAP_IDLE:   n = tms ? TAP_SEL_DR : TAP_IDLE;
         TAP_SEL_DR: n = tms ? TAP_SEL_IR : TAP_CAP_DR;
         TAP_CAP_DR: n = tms ? TAP_EX1_DR : TAP_SH_DR;
         TAP_SH_DR:  n = tms ? TAP_EX1_DR : TAP_SH_DR;
         TAP_EX1_DR: n = tms ? TAP_UPD_DR : TAP_PAU_DR;
         TAP_PAU_DR: n = tms ? TAP_EX2_DR : TAP_PAU_DR;
         TAP_EX2_DR: n = tms ? TAP_UPD_DR : TAP_SH_DR;
         TAP_UPD_DR: n = tms ? TAP_SEL_DR : TAP_IDLE;
         TAP_SEL_IR: n = tms ? TAP_RESET  : TAP_CAP_IR;
         TAP_CAP_IR: n = tms ? TAP_EX1_IR : TAP_SH_IR;
         TAP_SH_IR:  n = tms ? TAP_EX1_IR : TAP_SH_IR;
         TAP_EX1_IR: n = tms ? TAP_UPD_IR : TAP_PAU_IR;
         TAP_PAU_IR: n = tms ? TAP_EX2_IR : TAP_PAU_IR;
         TAP_EX2_IR: n = tms ? TAP_UPD_IR : TAP_SH_IR;
         TAP_UPD_IR: n = tms ? TAP_SEL_DR : TAP_IDLE;
         default:    n = TAP_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
   import bscan_pkg::*;
(
   input  logic    tck_i,
   input  logic    rst_n_i,
   input  logic    tms_i,
   output tap_st_e st_q,
   output tap_st_e st_nxt
);

   assign st_nxt = tap_next(st_q, tms_i);

   always_ff @(posedge tck_i or negedge rst_n_i) begin
      if (!rst_n_i) st_q <= TAP_RESET;
      else          st_q <= st_nxt;
   end

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
   import bscan_pkg::*;
#(
   parameter int unsigned IR_W = 3
) (
   input  logic            tck_i,
   input  logic            rst_n_i,
   input  logic            tdi_i,
   input  logic            cap_i,
   input  logic            sh_i,
   input  logic            upd_i,
   input  logic            go_rst_i,
   output logic            ir_lsb_o,
   output logic [IR_W-1:0] ir_cur_o,
   output dr_sel_e         dr_sel_o,
   output logic            op_extest_o,
   output logic            op_sampz_o
);

   localparam logic [IR_W-1:0] C_CAP = IR_W'(1);
   localparam logic [IR_W-1:0] C_EXT = IR_W'(OP_EXTEST);
   localparam logic [IR_W-1:0] C_IDC = IR_W'(OP_IDCODE);
   localparam logic [IR_W-1:0] C_SZ  = IR_W'(OP_SAMPZ);
   localparam logic [IR_W-1:0] C_SMP = IR_W'(OP_SAMPLE);

   logic [IR_W-1:0] sh_q;

   always_ff @(posedge tck_i or negedge rst_n_i) begin
      if (!rst_n_i)  sh_q <= C_CAP;
      else if (cap_i) sh_q <= C_CAP;
      else if (sh_i)  sh_q <= {tdi_i, sh_q[IR_W-1:1]};
   end

   // current instruction: reset target is the identification code
   always_ff @(posedge tck_i or negedge rst_n_i) begin
      if (!rst_n_i)      ir_cur_o <= C_IDC;
      else if (go_rst_i) ir_cur_o <= C_IDC;
      else if (upd_i)    ir_cur_o <= sh_q;
   end

   assign ir_lsb_o = sh_q[0];

   always_comb begin
      dr_sel_o    = DR_BYP;
      op_extest_o = 1'b0;
      op_sampz_o  = 1'b0;
      if (ir_cur_o == C_EXT) begin
         dr_sel_o    = DR_BND;
         op_extest_o = 1'b1;
      end else if (ir_cur_o == C_IDC) begin
         dr_sel_o = DR_IDC;
      end else if (ir_cur_o == C_SZ) begin
         dr_sel_o   = DR_BND;
         op_sampz_o = 1'b1;
      end else if (ir_cur_o == C_SMP) begin
         dr_sel_o = DR_BND;
      end
   end

endmodule

// File: rtl/bscan_dr_aux.sv
module bscan_dr_aux #(
   parameter int unsigned      ID_W    = 32,
   parameter logic [ID_W-1:0]  ID_CODE = 32'h1D0C_B069
) (
   input  logic tck_i,
   input  logic rst_n_i,
   input  logic tdi_i,
   input  logic cap_i,
   input  logic sh_i,
   input  logic sel_id_i,
   input  logic sel_byp_i,
   output logic id_lsb_o,
   output logic byp_o
);

   logic [ID_W-1:0] id_q;

   always_ff @(posedge tck_i or negedge rst_n_i) begin
      if (!rst_n_i)                id_q <= ID_CODE;
      else if (sel_id_i && cap_i)  id_q <= ID_CODE;
      else if (sel_id_i && sh_i)   id_q <= {tdi_i, id_q[ID_W-1:1]};
   end

   always_ff @(posedge tck_i or negedge rst_n_i) begin
      if (!rst_n_i)                byp_o <= 1'b0;
      else if (sel_byp_i && cap_i) byp_o <= 1'b0;
      else if (sel_byp_i && sh_i)  byp_o <= tdi_i;
   end

   assign id_lsb_o = id_q[0];

endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr #(
   parameter int unsigned LEN      = 109,
   parameter int unsigned OEN_CELL = 108
) (
   input  logic           tck_i,
   input  logic           rst_n_i,
   input  logic           tdi_i,
   input  logic           sel_i,
   input  logic           cap_i,
   input  logic           sh_i,
   input  logic           upd_i,
   input  logic           go_rst_i,
   input  logic [LEN-1:0] pins_i,
   output logic           lsb_o,
   output logic [LEN-1:0] pre_o
);

   logic [LEN-1:0] sh_q;
   logic [LEN-1:0] ser_in;

   for (genvar c = 0; c < LEN; c++) begin : g_cell
      logic sh_r;
      logic pre_r;

      if (c == LEN - 1) begin : g_tail
         assign ser_in[c] = tdi_i;
      end else begin : g_body
         assign ser_in[c] = sh_q[c+1];
      end

      always_ff @(posedge tck_i or negedge rst_n_i) begin
         if (!rst_n_i)            sh_r <= 1'b0;
         else if (sel_i && cap_i) sh_r <= pins_i[c];
         else if (sel_i && sh_i)  sh_r <= ser_in[c];
      end

      if (c == OEN_CELL) begin : g_oen
         // output-bus enable cell: preset to drive
         always_ff @(posedge tck_i or negedge rst_n_i) begin
            if (!rst_n_i)            pre_r <= 1'b1;
            else if (go_rst_i)       pre_r <= 1'b1;
            else if (sel_i && upd_i) pre_r <= sh_r;
         end
      end else begin : g_data
         always_ff @(posedge tck_i or negedge rst_n_i) begin
            if (!rst_n_i)            pre_r <= 1'b0;
            else if (sel_i && upd_i) pre_r <= sh_r;
         end
      end

      assign sh_q[c]  = sh_r;
      assign pre_o[c] = pre_r;
   end

   assign lsb_o = sh_q[0];

endmodule

// File: rtl/bscan_tap_ctl.sv
module bscan_tap_ctl
   import bscan_pkg::*;
#(
   parameter int unsigned     IR_W     = 3,
   parameter int unsigned     ID_W     = 32,
   parameter logic [ID_W-1:0] ID_CODE  = 32'h1D0C_B069,
   parameter int unsigned     BSR_LEN  = 109,
   parameter int unsigned     OEN_CELL = 108
) (
   input  logic               tck_i,
   input  logic               rst_n_i,
   input  logic               tms_i,
   input  logic               tdi_i,
   output logic               tdo_o,
   output logic               tdo_en_o,
   input  logic [BSR_LEN-1:0] pin_smp_i,
   output logic [BSR_LEN-1:0] pin_drv_o,
   output logic               bnd_drive_o,
   output logic               q_hiz_o
);

   if (IR_W < 3) begin : g_chk_ir
      $error("IR_W must hold the 3-bit opcodes");
   end
   if (OEN_CELL >= BSR_LEN) begin : g_chk_oen
      $error("OEN_CELL must lie inside the boundary register");
   end
   if (ID_CODE[0] != 1'b1) begin : g_chk_id
      $error("identification code must have bit 0 set");
   end

   tap_st_e         st_q, st_nxt;
   logic [IR_W-1:0] ir_cur;
   dr_sel_e         dr_sel;
   logic            op_extest, op_sampz;
   logic            ir_lsb, id_lsb, byp_bit, bsr_lsb;
   logic [BSR_LEN-1:0] pre_q;
   logic            cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir, go_rst;
   logic            dr_lsb;

   bscan_fsm u_fsm (
      .tck_i  (tck_i),
      .rst_n_i(rst_n_i),
      .tms_i  (tms_i),
      .st_q   (st_q),
      .st_nxt (st_nxt)
   );

   assign cap_dr = (st_q == TAP_CAP_DR);
   assign sh_dr  = (st_q == TAP_SH_DR);
   assign upd_dr = (st_q == TAP_UPD_DR);
   assign cap_ir = (st_q == TAP_CAP_IR);
   assign sh_ir  = (st_q == TAP_SH_IR);
   assign upd_ir = (st_q == TAP_UPD_IR);
   assign go_rst = (st_nxt == TAP_RESET);

   bscan_ir #(.IR_W(IR_W)) u_ir (
      .tck_i      (tck_i),
      .rst_n_i    (rst_n_i),
      .tdi_i      (tdi_i),
      .cap_i      (cap_ir),
      .sh_i       (sh_ir),
      .upd_i      (upd_ir),
      .go_rst_i   (go_rst),
      .ir_lsb_o   (ir_lsb),
      .ir_cur_o   (ir_cur),
      .dr_sel_o   (dr_sel),
      .op_extest_o(op_extest),
      .op_sampz_o (op_sampz)
   );

   bscan_dr_aux #(.ID_W(ID_W), .ID_CODE(ID_CODE)) u_aux (
      .tck_i    (tck_i),
      .rst_n_i  (rst_n_i),
      .tdi_i    (tdi_i),
      .cap_i    (cap_dr),
      .sh_i     (sh_dr),
      .sel_id_i (dr_sel == DR_IDC),
      .sel_byp_i(dr_sel == DR_BYP),
      .id_lsb_o (id_lsb),
      .byp_o    (byp_bit)
   );

   bscan_bsr #(.LEN(BSR_LEN), .OEN_CELL(OEN_CELL)) u_bsr (
      .tck_i   (tck_i),
      .rst_n_i (rst_n_i),
      .tdi_i   (tdi_i),
      .sel_i   (dr_sel == DR_BND),
      .cap_i   (cap_dr),
      .sh_i    (sh_dr),
      .upd_i   (upd_dr),
      .go_rst_i(go_rst),
      .pins_i  (pin_smp_i),
      .lsb_o   (bsr_lsb),
      .pre_o   (pre_q)
   );

   always_comb begin
      case (dr_sel)
         DR_IDC:  dr_lsb = id_lsb;
         DR_BND:  dr_lsb = bsr_lsb;
         default: dr_lsb = byp_bit;
      endcase
   end

   // serial output is retimed to the falling edge
   always_ff @(negedge tck_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         tdo_o    <= 1'b0;
         tdo_en_o <= 1'b0;
      end else begin
         tdo_en_o <= sh_ir | sh_dr;
         tdo_o    <= sh_ir ? ir_lsb : (sh_dr ? dr_lsb : 1'b0);
      end
   end

   assign pin_drv_o   = pre_q;
   assign bnd_drive_o = op_extest;
   assign q_hiz_o     = op_sampz | (op_extest & ~pre_q[OEN_CELL]);

endmodule

// File: rtl/bscan_tap_ctl_chk.sv
module bscan_tap_ctl_chk
   import bscan_pkg::*;
#(
   parameter int unsigned IR_W     = 3,
   parameter int unsigned BSR_LEN  = 109,
   parameter int unsigned OEN_CELL = 108
) (
   input logic               tck,
   input logic               rst_n,
   input logic               tms,
   input tap_st_e            st,
   input logic [IR_W-1:0]    ir_cur,
   input logic [BSR_LEN-1:0] pre_q,
   input logic               tdo_en,
   input logic               bnd_drive,
   input logic               q_hiz
);

   localparam logic [IR_W-1:0] K_EXT = IR_W'(OP_EXTEST);
   localparam logic [IR_W-1:0] K_IDC = IR_W'(OP_IDCODE);
   localparam logic [IR_W-1:0] K_SZ  = IR_W'(OP_SAMPZ);
   localparam logic [IR_W-1:0] K_SMP = IR_W'(OP_SAMPLE);

   a_r1_reset_idcode: assert property (@(posedge tck) disable iff (!rst_n)
      (st == TAP_RESET) |-> (ir_cur == K_IDC && !bnd_drive && !q_hiz));

   a_r2_five_high_reset: assert property (@(posedge tck) disable iff (!rst_n)
      (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (st == TAP_RESET));

   a_r3_ir_moves_at_update: assert property (@(posedge tck) disable iff (!rst_n)
      (ir_cur != $past(ir_cur)) |-> ($past(st) == TAP_UPD_IR || st == TAP_RESET));

   a_r7_sample_functional: assert property (@(posedge tck) disable iff (!rst_n)
      (ir_cur == K_SMP) |-> (!bnd_drive && !q_hiz));

   a_r8_preload_moves_at_update: assert property (@(posedge tck) disable iff (!rst_n)
      (pre_q != $past(pre_q)) |-> ($past(st) == TAP_UPD_DR || st == TAP_RESET));

   a_r9_extest_ctl: assert property (@(posedge tck) disable iff (!rst_n)
      (ir_cur == K_EXT) |-> (bnd_drive && (q_hiz == !pre_q[OEN_CELL])));

   a_r10_sampz_hiz: assert property (@(posedge tck) disable iff (!rst_n)
      (ir_cur == K_SZ) |-> (q_hiz && !bnd_drive));

   a_r11_oen_preset: assert property (@(posedge tck) disable iff (!rst_n)
      (st == TAP_RESET) |-> pre_q[OEN_CELL]);

   a_r12_tdo_en_shift: assert property (@(posedge tck) disable iff (!rst_n)
      tdo_en == (st == TAP_SH_IR || st == TAP_SH_DR));

endmodule

bind bscan_tap_ctl bscan_tap_ctl_chk #(
   .IR_W(IR_W), .BSR_LEN(BSR_LEN), .OEN_CELL(OEN_CELL)
) u_chk (
   .tck      (tck_i),
   .rst_n    (rst_n_i),
   .tms      (tms_i),
   .st       (st_q),
   .ir_cur   (ir_cur),
   .pre_q    (pre_q),
   .tdo_en   (tdo_en_o),
   .bnd_drive(bnd_drive_o),
   .q_hiz    (q_hiz_o)
);

// File: tb/bscan_tap_ctl_tb.sv
`timescale 1ns/1ps
module bscan_tap_ctl_tb;

   localparam int unsigned BSR_LEN = 109;
   localparam logic [31:0]  IDC    = 32'h1D0C_B069;
   localparam logic [127:0] MASK   = (128'd1 << BSR_LEN) - 128'd1;
   localparam logic [127:0] BIT_OE = 128'd1 << 108;
   localparam logic [127:0] PAT_A  = 128'h3C5A_9E17_0F2D_B486_71C3_E95A_2B60_D4F9;
   localparam logic [127:0] PAT_A2 = 128'hA1B2_C3D4_E5F6_0718_293A_4B5C_6D7E_8F90;
   localparam logic [127:0] PAT_B  = (128'h9F0E_1D2C_3B4A_5968_7786_95A4_B3C2_D1E0 | BIT_OE) & MASK;
   localparam logic [127:0] PAT_C  = (128'h5566_7788_99AA_BBCC_DDEE_FF00_1122_3344 & ~BIT_OE) & MASK;
   localparam logic [127:0] PAT_D  = (128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210 & ~BIT_OE) & MASK;

   logic tck = 1'b0;
   logic rst_n, tms, tdi;
   logic tdo, tdo_en, bnd_drive, q_hiz;
   logic [BSR_LEN-1:0] pins, pin_drv;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   always #4 tck = ~tck;

   bscan_tap_ctl #(
      .IR_W(3), .ID_W(32), .ID_CODE(IDC), .BSR_LEN(BSR_LEN), .OEN_CELL(108)
   ) u_dut (
      .tck_i(tck), .rst_n_i(rst_n), .tms_i(tms), .tdi_i(tdi),
      .tdo_o(tdo), .tdo_en_o(tdo_en),
      .pin_smp_i(pins), .pin_drv_o(pin_drv),
      .bnd_drive_o(bnd_drive), .q_hiz_o(q_hiz)
   );

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d);
      @(negedge tck); #1;
      tms = m; tdi = d;
      @(posedge tck); #1;
   endtask

   // scoreboard monitor: one expected bit per enabled falling edge
   always @(negedge tck) begin
      #2;
      if (rst_n === 1'b1 && tdo_en === 1'b1) begin
         logic held;
         if (exp_q.size() == 0) begin
            chk("R12 enable with nothing scheduled", 128'd1, 128'd0);
         end else begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {127'd0, tdo}, {127'd0, e});
         end
         held = tdo;
         @(posedge tck); #1;
         chk("R12 TDO held across rising edge", {127'd0, tdo}, {127'd0, held});
      end
   end

   task automatic load_ir(input logic [2:0] code);
      logic b0, h0;
      b0 = bnd_drive; h0 = q_hiz;
      exp_q.push_back(1'b1); tag_q.push_back("R3 capture pattern bit0");
      exp_q.push_back(1'b0); tag_q.push_back("R3 capture pattern bit1");
      exp_q.push_back(1'b0); tag_q.push_back("R3 capture pattern bit2");
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 3; i++) step(i == 2, code[i]);
      chk("R3 outputs unchanged before Update-IR", {126'd0, bnd_drive, q_hiz}, {126'd0, b0, h0});
      step(1, 0);
      step(0, 0);
   endtask

   task automatic scan_dr(input int len, input logic [127:0] din,
                          input logic [127:0] dexp, input string tag);
      for (int i = 0; i < len; i++) begin
         exp_q.push_back(dexp[i]);
         tag_q.push_back(tag);
      end
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < len; i++) step(i == len - 1, din[i]);
      step(1, 0);
      step(0, 0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [2:0] rsv [3];
      rsv[0] = 3'b011; rsv[1] = 3'b101; rsv[2] = 3'b110;
      rst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
      pins = PAT_A[BSR_LEN-1:0];
      repeat (3) @(posedge tck);
      @(negedge tck); rst_n = 1'b1;
      #1;
      chk("R1 reset tdo_en", {127'd0, tdo_en}, 128'd0);
      chk("R1 reset output control", {126'd0, bnd_drive, q_hiz}, 128'd0);
      chk("R11 reset preload", {19'd0, pin_drv}, BIT_OE);
      step(0, 0);

      // identification code after reset
      scan_dr(32, 128'h0, {96'd0, IDC}, "R4 id code (R1 default)");
      chk("R12 idle tdo_en low", {126'd0, tdo_en, tdo}, 128'd0);

      // bypass and reserved codes
      load_ir(3'b111);
      scan_dr(8, 128'hB2, {119'd0, 8'hB2, 1'b0}, "R5 bypass delay");
      for (int k = 0; k < 3; k++) begin
         load_ir(rsv[k]);
         scan_dr(5, 128'h1D, {122'd0, 5'h1D, 1'b0}, "R6 reserved acts as bypass");
      end

      // sample/preload
      load_ir(3'b100);
      chk("R7 functional control", {126'd0, bnd_drive, q_hiz}, 128'd0);
      scan_dr(BSR_LEN, PAT_B, PAT_A & MASK, "R7 pin snapshot");
      chk("R8 preload after Update-DR", {19'd0, pin_drv}, PAT_B);
      chk("R7 still functional", {126'd0, bnd_drive, q_hiz}, 128'd0);

      // non-boundary instruction leaves preload alone
      load_ir(3'b001);
      scan_dr(32, 128'hFFFF_FFFF, {96'd0, IDC}, "R4 id code reloaded");
      chk("R8 preload kept under IDCODE", {19'd0, pin_drv}, PAT_B);

      // extest
      load_ir(3'b000);
      chk("R9 extest drives, cell108=1", {126'd0, bnd_drive, q_hiz}, {126'd0, 2'b10});
      pins = PAT_A2[BSR_LEN-1:0];
      scan_dr(BSR_LEN, PAT_C, PAT_A2 & MASK, "R9 extest capture");
      chk("R9 preload C", {19'd0, pin_drv}, PAT_C);
      chk("R9 cell108=0 tri-states", {126'd0, bnd_drive, q_hiz}, {126'd0, 2'b11});

      // reset from Pause-DR via five high TMS edges
      load_ir(3'b111);
      step(1, 0); step(0, 0); step(1, 0); step(0, 0);
      for (int i = 0; i < 5; i++) step(1, 0);
      chk("R1 control after reset entry", {126'd0, bnd_drive, q_hiz}, 128'd0);
      step(0, 0);
      chk("R11 cell108 preset, others kept", {19'd0, pin_drv}, PAT_C | BIT_OE);
      scan_dr(32, 128'h0, {96'd0, IDC}, "R2 reset reached, id selected");
      load_ir(3'b000);
      chk("R11 extest drives after preset", {126'd0, bnd_drive, q_hiz}, {126'd0, 2'b10});

      // sample z
      load_ir(3'b010);
      chk("R10 sample z tri-state", {126'd0, bnd_drive, q_hiz}, {126'd0, 2'b01});
      scan_dr(BSR_LEN, PAT_D, PAT_A2 & MASK, "R10 boundary selected");
      chk("R8 preload under sample z", {19'd0, pin_drv}, PAT_D);
      chk("R10 tri-state holds", {126'd0, bnd_drive, q_hiz}, {126'd0, 2'b01});
      load_ir(3'b001);
      chk("R10 released at Update-IR", {126'd0, bnd_drive, q_hiz}, 128'd0);
      chk("R8 preload kept", {19'd0, pin_drv}, PAT_D);

      repeat (3) step(0, 0);
      chk("R12 all scheduled bits seen", 128'(exp_q.size()), 128'd0);
      chk("R12 idle tdo low", {126'd0, tdo_en, tdo}, 128'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule